// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits beside the ECC checker of a DRAM controller and keeps a record of the most important memory error seen since software last cleared it. The checker delivers two single-cycle event strobes, one for correctable and one for uncorrectable errors. Each strobe comes with the failing block address, an 8-bit syndrome and the channel that saw the error. The block turns these events into sticky status flags and a snapshot of the error's details. When software has enabled it, the block also raises a system-error pulse.

The snapshot follows a severity rule. The first error into an empty log fills it. An uncorrectable error replaces a log that holds only a correctable error. Nothing else may overwrite a log once it is held. Software reads the registers through a small indexed port with one cycle of read latency. It clears the two status flags by writing ones to them. Once both flags are clear, the log is free to capture the next event of either kind.

Register indices on the port:

| Index | Register | Contents |
|---|---|---|
| 0 | Status | bit 0 = correctable, bit 7 = uncorrectable |
| 1 | Command | bit 7 = SERR on correctable, bit 8 = SERR on uncorrectable |
| 2 | Address | block address in bits 31:12, bits 11:0 zero |
| 3 | Syndrome | 8-bit syndrome |
| 4 | Channel | channel in bit 0, bits 7:1 zero |

Top module: `ecc_err_log`

## Requirements
- R1: While reset is high, every register resets to zero. On the first read after reset, each index returns 0, and serr is low.
- R2: A correctable strobe into an empty log sets status bit 0. The same strobe loads the address (block address in bits 31:12, bits 11:0 zero), the syndrome, and the channel (bit 0, bits 7:1 zero).
- R3: An uncorrectable strobe into an empty log sets status bit 7 and loads address, syndrome and channel.
- R4: An uncorrectable strobe while only status bit 0 is set replaces address, syndrome and channel with the new error's values. After it, status reads 0x0081.
- R5: A correctable strobe while either status bit is set leaves address, syndrome and channel unchanged.
- R6: An uncorrectable strobe while status bit 7 is set leaves address, syndrome and channel unchanged.
- R7: A write to index 0 clears bit 0 where the written bit 0 is one, and clears bit 7 where the written bit 7 is one. Written zeros leave those bits unchanged.
- R8: When a clear of a status bit and a new strobe of the same type fall in the same cycle, the bit stays set.
- R9: Once both status bits are clear, the next strobe of either type loads address, syndrome and channel again.
- R10: The command register keeps only written bits 7 and 8. Every other command and status bit reads zero, and writes to those bits are ignored.
- R11: serr is high for exactly the one cycle after a strobe whose type was not yet logged and whose command enable bit is set. Otherwise serr is low.
- R12: reg_rdata shows, one cycle later, the register selected by reg_idx before that cycle's update. Indices 5 to 7 read zero.
- R13: Simultaneous correctable and uncorrectable strobes into an empty log set both status bits and capture the shared data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | Correctable error strobe |
| ue_in | input | 1 | Uncorrectable error strobe |
| err_blk | input | 20 | Failing block address (physical address bits 31:12) |
| err_syn | input | 8 | Syndrome of the error |
| err_chan | input | 1 | Channel of the error |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Registered read data |
| serr | output | 1 | System-error pulse |

## Verification
The hardest states to reach are the collision cycles. In one, a software clear lands in the same cycle as a new error of the same kind. In the other, an uncorrectable error arrives while a correctable log is held and must displace it. Directed phases build each preceding log state on purpose and then apply the colliding stimulus on one exact cycle. A long random phase then runs frequent strobes alongside random clears and reads. The behavioural model is compared on every clock, so each overwrite and hold decision is checked through the read port.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [2:0] {
    IDX_STAT = 3'd0,
    IDX_CMD  = 3'd1,
    IDX_ADDR = 3'd2,
    IDX_SYN  = 3'd3,
    IDX_CHAN = 3'd4
  } reg_idx_e;

  localparam int CE_BIT      = 0;
  localparam int UE_BIT      = 7;
  localparam int SERR_CE_BIT = 7;
  localparam int SERR_UE_BIT = 8;
endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status (
  input  logic clk,
  input  logic rst,
  input  logic ce_in,
  input  logic ue_in,
  input  logic clr_ce,
  input  logic clr_ue,
  output logic st_ce,
  output logic st_ue,
  output logic new_ce,
  output logic new_ue
);
  // A strobe counts as new only while its flag is still clear
  assign new_ce = ce_in & ~st_ce;
  assign new_ue = ue_in & ~st_ue;

  // A same-cycle strobe overrides the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_ce <= 1'b0;
      st_ue <= 1'b0;
    end else begin
      st_ce <= (st_ce & ~clr_ce) | ce_in;
      st_ue <= (st_ue & ~clr_ue) | ue_in;
    end
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_in,
  input  logic             ue_in,
  input  logic             st_ce,
  input  logic             st_ue,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [SYN_W-1:0] syn_in,
  input  logic             chan_in,
  output logic [BLK_W-1:0] blk_q,
  output logic [SYN_W-1:0] syn_q,
  output logic             chan_q
);
  logic take_ue, take_ce, take;

  // Severity rule: an uncorrectable error may displace a correctable log.
  // A correctable error only fills an empty log.
  assign take_ue = ue_in & ~st_ue;
  assign take_ce = ce_in & ~ue_in & ~st_ce & ~st_ue;
  assign take    = take_ue | take_ce;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (take) begin
      blk_q  <= blk_in;
      syn_q  <= syn_in;
      chan_q <= chan_in;
    end
  end
endmodule

// File: rtl/ecc_log_csr.sv
module ecc_log_csr
  import ecc_log_pkg::*;
#(
  parameter int STAT_W    = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  parameter int BLK_W     = 20,
  parameter int BLK_SHIFT = 12,
  parameter int SYN_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic              st_ce,
  input  logic              st_ue,
  input  logic              new_ce,
  input  logic              new_ue,
  input  logic [BLK_W-1:0]  blk_q,
  input  logic [SYN_W-1:0]  syn_q,
  input  logic              chan_q,
  output logic [STAT_W-1:0] cmd_q,
  output logic              clr_ce,
  output logic              clr_ue,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              serr
);
  logic wr_stat, wr_cmd;
  logic [STAT_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_next;

  assign wr_stat = reg_wr && (reg_idx == IDX_W'(IDX_STAT));
  assign wr_cmd  = reg_wr && (reg_idx == IDX_W'(IDX_CMD));
  assign clr_ce  = wr_stat && reg_wdata[CE_BIT];
  assign clr_ue  = wr_stat && reg_wdata[UE_BIT];

  // Command register: only the enable bits hold a flop
  for (genvar b = 0; b < STAT_W; b++) begin : g_cmd
    if (b == SERR_CE_BIT || b == SERR_UE_BIT) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)         cmd_q[b] <= 1'b0;
        else if (wr_cmd) cmd_q[b] <= reg_wdata[b];
      end
    end else begin : g_zero
      assign cmd_q[b] = 1'b0;
    end
  end

  always_comb begin
    stat_word         = '0;
    stat_word[CE_BIT] = st_ce;
    stat_word[UE_BIT] = st_ue;
  end

  always_comb begin
    rd_next = '0;
    case (reg_idx)
      IDX_W'(IDX_STAT): rd_next = DATA_W'(stat_word);
      IDX_W'(IDX_CMD):  rd_next = DATA_W'(cmd_q);
      IDX_W'(IDX_ADDR): rd_next = DATA_W'({blk_q, {BLK_SHIFT{1'b0}}});
      IDX_W'(IDX_SYN):  rd_next = DATA_W'(syn_q);
      IDX_W'(IDX_CHAN): rd_next = DATA_W'(chan_q);
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      serr      <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      serr      <= (new_ce & cmd_q[SERR_CE_BIT]) | (new_ue & cmd_q[SERR_UE_BIT]);
    end
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 12,
  parameter int SYN_W     = 8,
  parameter int STAT_W    = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_in,
  input  logic              ue_in,
  input  logic [BLK_W-1:0]  err_blk,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              serr
);
  logic st_ce, st_ue, new_ce, new_ue, clr_ce, clr_ue, cap_chan;
  logic [BLK_W-1:0]  cap_blk;
  logic [SYN_W-1:0]  cap_syn;
  logic [STAT_W-1:0] cmd_q;

  ecc_log_status u_status (
    .clk(clk), .rst(rst), .ce_in(ce_in), .ue_in(ue_in),
    .clr_ce(clr_ce), .clr_ue(clr_ue), .st_ce(st_ce), .st_ue(st_ue),
    .new_ce(new_ce), .new_ue(new_ue)
  );

  ecc_log_capture #(.BLK_W(BLK_W), .SYN_W(SYN_W)) u_capture (
    .clk(clk), .rst(rst), .ce_in(ce_in), .ue_in(ue_in),
    .st_ce(st_ce), .st_ue(st_ue), .blk_in(err_blk), .syn_in(err_syn),
    .chan_in(err_chan), .blk_q(cap_blk), .syn_q(cap_syn), .chan_q(cap_chan)
  );

  ecc_log_csr #(
    .STAT_W(STAT_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .BLK_W(BLK_W), .BLK_SHIFT(BLK_SHIFT), .SYN_W(SYN_W)
  ) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .st_ce(st_ce), .st_ue(st_ue),
    .new_ce(new_ce), .new_ue(new_ue), .blk_q(cap_blk), .syn_q(cap_syn),
    .chan_q(cap_chan), .cmd_q(cmd_q), .clr_ce(clr_ce), .clr_ue(clr_ue),
    .reg_rdata(reg_rdata), .serr(serr)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int BLK_W  = 20,
  parameter int SYN_W  = 8,
  parameter int STAT_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_in,
  input logic              ue_in,
  input logic [SYN_W-1:0]  err_syn,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [STAT_W-1:0] reg_wdata,
  input logic              serr,
  input logic              st_ce,
  input logic              st_ue,
  input logic [STAT_W-1:0] cmd_q,
  input logic [SYN_W-1:0]  cap_syn,
  input logic [BLK_W-1:0]  cap_blk
);
  logic wr_stat;
  assign wr_stat = reg_wr && (reg_idx == '0);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!st_ce && !st_ue && !serr && cmd_q == '0)); // R1
  AST_CE_SETS: assert property (@(posedge clk) disable iff (rst)
    ce_in |=> st_ce); // R2
  AST_UE_SETS: assert property (@(posedge clk) disable iff (rst)
    ue_in |=> st_ue); // R3
  AST_UE_OVERWRITES: assert property (@(posedge clk) disable iff (rst)
    (ue_in && st_ce && !st_ue) |=> (cap_syn == $past(err_syn))); // R4
  AST_CE_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (ce_in && !ue_in && (st_ce || st_ue)) |=> ($stable(cap_syn) && $stable(cap_blk))); // R5
  AST_UE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ue_in && st_ue) |=> ($stable(cap_syn) && $stable(cap_blk))); // R6
  AST_W1C_CE: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[0] && !ce_in) |=> !st_ce); // R7
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[7] && ue_in) |=> st_ue); // R8
  AST_CMD_RESERVED: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_q & ~STAT_W'(16'h0180)) == 0); // R10
  AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    serr |-> $past((ce_in && !st_ce && cmd_q[7]) || (ue_in && !st_ue && cmd_q[8]))); // R11
endmodule

bind ecc_err_log ecc_err_log_chk #(
  .BLK_W(BLK_W), .SYN_W(SYN_W), .STAT_W(STAT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .ce_in(ce_in), .ue_in(ue_in), .err_syn(err_syn),
  .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .serr(serr),
  .st_ce(st_ce), .st_ue(st_ue), .cmd_q(cmd_q), .cap_syn(cap_syn),
  .cap_blk(cap_blk)
);

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_in = 1'b0, ue_in = 1'b0, err_chan = 1'b0, reg_wr = 1'b0;
  logic [19:0] err_blk = '0;
  logic [7:0]  err_syn = '0;
  logic [2:0]  reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr;

  int checks = 0, fails = 0;
  string tag = "R1";

  // Reference model state
  logic m_ce = 0, m_ue = 0, m_ch = 0, e_serr = 0;
  logic [19:0] m_blk = '0;
  logic [7:0]  m_syn = '0;
  logic [15:0] m_cmd = '0;
  logic [31:0] e_rd = '0;
  logic [2:0]  e_idx = '0;

  ecc_err_log uut (
    .clk(clk), .rst(rst), .ce_in(ce_in), .ue_in(ue_in), .err_blk(err_blk),
    .err_syn(err_syn), .err_chan(err_chan), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr(serr)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [2:0] i);
    case (i)
      3'd0: return {16'h0, 8'h0, m_ue, 6'h0, m_ce};
      3'd1: return {16'h0, m_cmd};
      3'd2: return {m_blk, 12'h000};
      3'd3: return {24'h0, m_syn};
      3'd4: return {31'h0, m_ch};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ce = 0; m_ue = 0; m_ch = 0; m_blk = '0; m_syn = '0; m_cmd = '0;
      e_rd = '0; e_serr = 0; e_idx = '0;
    end else begin
      logic take, clr0, clr7;
      e_rd   = model_read(reg_idx);
      e_idx  = reg_idx;
      e_serr = (ce_in && !m_ce && m_cmd[7]) || (ue_in && !m_ue && m_cmd[8]);
      take   = (ue_in && !m_ue) || (ce_in && !ue_in && !m_ce && !m_ue);
      if (take) begin
        m_blk = err_blk; m_syn = err_syn; m_ch = err_chan;
      end
      clr0 = reg_wr && reg_idx == 3'd0 && reg_wdata[0];
      clr7 = reg_wr && reg_idx == 3'd0 && reg_wdata[7];
      m_ce = (m_ce && !clr0) || ce_in;
      m_ue = (m_ue && !clr7) || ue_in;
      if (reg_wr && reg_idx == 3'd1) m_cmd = reg_wdata & 16'h0180;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare outputs with the model away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(reg_rdata === e_rd, $sformatf("rdata idx %0d (R12)", e_idx), reg_rdata, e_rd);
      check(serr === e_serr, "serr (R11)", {31'h0, serr}, {31'h0, e_serr});
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    ce_in = 0; ue_in = 0; reg_wr = 0;
  endtask

  task automatic strobe(input bit c, input bit u, input logic [19:0] b,
                        input logic [7:0] s, input bit ch);
    ce_in = c; ue_in = u; err_blk = b; err_syn = s; err_chan = ch;
    tick(); idle();
  endtask

  task automatic wr(input logic [2:0] i, input logic [15:0] d);
    reg_wr = 1; reg_idx = i; reg_wdata = d; tick(); idle();
  endtask

  task automatic read_all();
    for (int i = 0; i < 8; i++) begin
      reg_idx = i[2:0]; tick();
    end
  endtask

  initial begin
    #(4ns * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1: reset state at the ports
    tag = "R1";
    check(serr === 1'b0, "serr after reset", {31'h0, serr}, 32'h0);
    check(reg_rdata === 32'h0, "rdata after reset", reg_rdata, 32'h0);
    read_all();

    tag = "R10"; wr(3'd1, 16'hFFFF); read_all(); wr(3'd0, 16'hFF7E); read_all();
    tag = "R2"; strobe(1, 0, 20'hABCDE, 8'h5A, 1); read_all();
    tag = "R5"; strobe(1, 0, 20'h11111, 8'h22, 0); read_all();
    tag = "R4"; strobe(0, 1, 20'h33333, 8'h44, 0); read_all();
    tag = "R6"; strobe(0, 1, 20'h55555, 8'h66, 1); read_all();
    tag = "R5"; strobe(1, 0, 20'h77777, 8'h88, 1); read_all();
    tag = "R7"; wr(3'd0, 16'h0000); read_all(); wr(3'd0, 16'h0001); read_all();
    wr(3'd0, 16'h0080); read_all();
    tag = "R8";
    strobe(1, 0, 20'h0F0F0, 8'h99, 1);
    ce_in = 1; reg_wr = 1; reg_idx = 3'd0; reg_wdata = 16'h0001; tick(); idle();
    read_all();
    tag = "R9"; wr(3'd0, 16'h0081); strobe(0, 1, 20'hFEDCB, 8'hAA, 1); read_all();
    tag = "R3"; wr(3'd0, 16'h0081); strobe(0, 1, 20'h00001, 8'h01, 0); read_all();
    tag = "R13"; wr(3'd0, 16'h0081); strobe(1, 1, 20'h2468A, 8'hC3, 1); read_all();
    tag = "R11"; wr(3'd0, 16'h0081); wr(3'd1, 16'h0080);
    strobe(0, 1, 20'h13579, 8'h3C, 0); strobe(1, 0, 20'h13570, 8'h3D, 0); read_all();
    wr(3'd0, 16'h0081); wr(3'd1, 16'h0000); strobe(1, 1, 20'h1, 8'h1, 1); read_all();
    wr(3'd1, 16'h0180);

    tag = "R12";
    for (int n = 0; n < 2000; n++) begin
      ce_in = ($urandom % 5) == 0;
      ue_in = ($urandom % 9) == 0;
      err_blk = 20'($urandom); err_syn = 8'($urandom); err_chan = 1'($urandom);
      reg_idx = 3'($urandom);
      reg_wr = ($urandom % 4) == 0 && reg_idx < 3'd2;
      reg_wdata = 16'($urandom);
      tick();
    end
    idle(); read_all();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule